// File: doc/BRIEF.md
# Masked Phase/Data Conditional Branch Unit

This unit evaluates the condition carried by a script transfer-control instruction in a bus controller and decides whether the branch is taken. A one-cycle start pulse presents the 32-bit control word. The unit can test the bus phase that was latched on a request edge, or the attention line when the controller acts as a target. It can also test the first received data byte against a compare value, with a per-bit mask that excludes bits. Either test, both of them, or neither may be enabled.

An instruction may ask the unit to stall until a fresh, unserviced bus phase has been latched before it makes the comparison. A phase that has been consumed this way is not reused by a later waiting instruction. The outcome is inverted or passed through according to a true/false polarity bit. It is reported as a registered one-cycle decision pulse together with a taken flag. Instruction fetch, target address arithmetic and the transfer engine sit outside this block.

Top module: `branch_cond_unit`

## Requirements
- R1: After reset `done_o` and `taken_o` are 0 and no unserviced phase is pending, so a waiting instruction issued first stalls until a `phase_new_i` pulse arrives.
- R2: With control bit 16 clear, `start_i` sampled in idle causes `done_o` to be 1 in exactly the cycle after the next clock edge, and for one cycle only.
- R3: Control bit 18 enables the data test: `first_byte_i` must equal control bits [7:0] at every bit position whose mask bit in control bits [15:8] is 0; bits with mask 1 are ignored.
- R4: In initiator mode (`target_mode_i`=0), control bit 17 enables the phase test, which is true when `phase_i` equals control bits [26:24].
- R5: In target mode (`target_mode_i`=1), control bit 17 turns the phase test into a test that `atn_i` is 1, and `phase_i` has no effect.
- R6: With both tests enabled the condition is the AND of the two; with neither enabled the condition is true.
- R7: `taken_o` is 1 when control bit 19 is 1 and the condition is true, or when bit 19 is 0 and the condition is false; it is 0 otherwise.
- R8: With control bit 16 set, no decision is made until an unserviced phase is pending. `done_o` then rises on the second edge after the edge that saw the phase pending, and the comparison uses the inputs present in the cycle before that edge.
- R9: A pending phase is consumed when a waiting instruction uses it. A `phase_new_i` pulse that arrives before the start is kept, and the next waiting instruction uses it without stalling.
- R10: `start_i` is ignored while an instruction is in progress; the decision follows the instruction already loaded and only one `done_o` pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load `ctrl_i` and begin evaluation (idle only) |
| ctrl_i | input | 32 | Transfer-control instruction word |
| first_byte_i | input | 8 | First received data byte |
| phase_i | input | 3 | Bus phase latched on the request edge |
| phase_new_i | input | 1 | Pulse: a new, unserviced phase has been latched |
| target_mode_i | input | 1 | 1 = target mode, 0 = initiator mode |
| atn_i | input | 1 | Attention line, active high |
| done_o | output | 1 | One-cycle decision-valid pulse |
| taken_o | output | 1 | Branch taken, valid with `done_o` |

## Verification
The bench uses a mask of 0x7F against a value of 0x80 with both possible top bits and noisy low bits. A design that inverts the mask sense, or masks the wrong operand, then decides on the low bits. Target-mode runs pair a matching phase with a low attention line, which exposes a design that still compares phases. Waiting runs check the exact latency after a phase strobe, a strobe that arrives before the start, and a second wait after a consumed phase. These catch a flag that never clears, or one that forgets an early strobe. A start pulse during a stall checks that the loaded instruction is not overwritten and that no second decision appears.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_DECIDE} bcu_state_e;

  localparam int CTRL_W   = 32;
  localparam int VAL_LSB  = 0;
  localparam int MASK_LSB = 8;
  localparam int WAIT_BIT = 16;
  localparam int PCMP_BIT = 17;
  localparam int DCMP_BIT = 18;
  localparam int POL_BIT  = 19;
  localparam int PH_LSB   = 24;
endpackage

// File: rtl/bcu_phase_tracker.sv
module bcu_phase_tracker (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic phase_new_i,
  input  logic consume_i,
  output logic pending_o
);
  // a fresh strobe wins over a same-cycle consume
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pending_o <= 1'b0;
    else         pending_o <= phase_new_i | (pending_o & ~consume_i);
  end
endmodule

// File: rtl/bcu_compare.sv
module bcu_compare #(
  parameter int DATA_W  = 8,
  parameter int PHASE_W = 3
) (
  input  logic               data_en_i,
  input  logic               phase_en_i,
  input  logic               jump_true_i,
  input  logic               target_mode_i,
  input  logic               atn_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic [PHASE_W-1:0] phase_ref_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic [DATA_W-1:0]  data_ref_i,
  input  logic [DATA_W-1:0]  mask_i,
  output logic               taken_o
);
  logic [DATA_W-1:0] bit_ok;
  logic phase_ok, data_ok, cond;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign bit_ok[b] = mask_i[b] | ~(data_i[b] ^ data_ref_i[b]);
  end

  assign data_ok  = &bit_ok;
  assign phase_ok = target_mode_i ? atn_i : (phase_i == phase_ref_i);
  assign cond     = (~phase_en_i | phase_ok) & (~data_en_i | data_ok);
  assign taken_o  = jump_true_i ? cond : ~cond;
endmodule

// File: rtl/bcu_fsm.sv
module bcu_fsm
  import bcu_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       wait_en_i,
  input  logic       pending_i,
  output bcu_state_e state_o,
  output logic       load_o,
  output logic       consume_o,
  output logic       decide_o
);
  bcu_state_e state_d;

  always_comb begin
    state_d   = state_o;
    load_o    = 1'b0;
    consume_o = 1'b0;
    decide_o  = 1'b0;
    unique case (state_o)
      ST_IDLE: if (start_i) begin
        load_o  = 1'b1;
        state_d = wait_en_i ? ST_WAIT : ST_DECIDE;
      end
      ST_WAIT: if (pending_i) begin
        consume_o = 1'b1;
        state_d   = ST_DECIDE;
      end
      ST_DECIDE: begin
        decide_o = 1'b1;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= ST_IDLE;
    else         state_o <= state_d;
  end
endmodule

// File: rtl/branch_cond_unit.sv
module branch_cond_unit
  import bcu_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int PHASE_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [CTRL_W-1:0]  ctrl_i,
  input  logic [DATA_W-1:0]  first_byte_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic               phase_new_i,
  input  logic               target_mode_i,
  input  logic               atn_i,
  output logic               done_o,
  output logic               taken_o
);
  logic [CTRL_W-1:0] ctrl_q;
  bcu_state_e        state_q;
  logic load, consume, decide, phase_pending, taken_c;

  bcu_phase_tracker u_trk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .phase_new_i (phase_new_i),
    .consume_i   (consume),
    .pending_o   (phase_pending)
  );

  bcu_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .wait_en_i (ctrl_i[WAIT_BIT]),
    .pending_i (phase_pending),
    .state_o   (state_q),
    .load_o    (load),
    .consume_o (consume),
    .decide_o  (decide)
  );

  bcu_compare #(.DATA_W(DATA_W), .PHASE_W(PHASE_W)) u_cmp (
    .data_en_i     (ctrl_q[DCMP_BIT]),
    .phase_en_i    (ctrl_q[PCMP_BIT]),
    .jump_true_i   (ctrl_q[POL_BIT]),
    .target_mode_i (target_mode_i),
    .atn_i         (atn_i),
    .phase_i       (phase_i),
    .phase_ref_i   (ctrl_q[PH_LSB +: PHASE_W]),
    .data_i        (first_byte_i),
    .data_ref_i    (ctrl_q[VAL_LSB +: DATA_W]),
    .mask_i        (ctrl_q[MASK_LSB +: DATA_W]),
    .taken_o       (taken_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      done_o  <= 1'b0;
      taken_o <= 1'b0;
    end else begin
      if (load) ctrl_q <= ctrl_i;
      done_o <= decide;
      if (decide) taken_o <= taken_c;
    end
  end
endmodule

// File: rtl/bcu_checker.sv
module bcu_checker
  import bcu_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [CTRL_W-1:0] ctrl_i,
  input logic              phase_new_i,
  input logic              done_o,
  input logic              taken_o,
  input bcu_state_e        state_i,
  input logic              pending_i,
  input logic [CTRL_W-1:0] ctrl_q_i
);
  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_nowait_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE && start_i && !ctrl_i[WAIT_BIT]) |-> ##2 done_o);

  p_no_cond_pol_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !ctrl_q_i[DCMP_BIT] && !ctrl_q_i[PCMP_BIT]) |-> (taken_o == ctrl_q_i[POL_BIT]));

  p_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_WAIT && !pending_i) |=> !done_o && state_i != ST_DECIDE);

  p_consume_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_WAIT && pending_i && !phase_new_i) |=> !pending_i);

  p_start_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ST_IDLE) |=> $stable(ctrl_q_i));
endmodule

bind branch_cond_unit bcu_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .ctrl_i      (ctrl_i),
  .phase_new_i (phase_new_i),
  .done_o      (done_o),
  .taken_o     (taken_o),
  .state_i     (state_q),
  .pending_i   (phase_pending),
  .ctrl_q_i    (ctrl_q)
);

// File: tb/tb_branch_cond_unit.sv
module tb_branch_cond_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] ctrl_i = '0;
  logic [7:0]  first_byte_i = '0;
  logic [2:0]  phase_i = '0;
  logic        phase_new_i = 1'b0;
  logic        target_mode_i = 1'b0;
  logic        atn_i = 1'b0;
  logic        done_o, taken_o;

  int n_chk = 0;
  int n_fail = 0;

  branch_cond_unit dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [31:0] mk(bit pol, bit dc, bit pc, bit wt,
                                     logic [2:0] ph, logic [7:0] msk, logic [7:0] val);
    return {5'b0, ph, 4'b0, pol, dc, pc, wt, msk, val};
  endfunction

  task automatic chk(logic act, logic exp, string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic chk_int(int act, int exp, string req);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic issue(logic [31:0] c, logic [7:0] b, logic [2:0] ph, bit tgt, bit atn);
    @(negedge clk_i);
    ctrl_i = c; first_byte_i = b; phase_i = ph; target_mode_i = tgt; atn_i = atn;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  // polls from the current negedge; checks latency, flag and pulse width
  task automatic expect_done(int lat_exp, logic exp_taken, string req);
    int lat = 0;
    while (lat < lat_exp + 6) begin
      @(negedge clk_i);
      lat++;
      if (done_o) break;
    end
    chk_int(lat, lat_exp, {req, " latency"});
    chk(taken_o, exp_taken, {req, " taken"});
    @(negedge clk_i);
    chk(done_o, 1'b0, {req, " pulse width"});
  endtask

  task automatic strobe_phase(logic [2:0] ph);
    @(negedge clk_i);
    phase_i = ph; phase_new_i = 1'b1;
    @(negedge clk_i);
    phase_new_i = 1'b0;
  endtask

  task automatic t_reset;
    chk(done_o, 1'b0, "R1 done after reset");
    chk(taken_o, 1'b0, "R1 taken after reset");
  endtask

  task automatic t_data_mask;
    issue(mk(1,1,0,0,0,8'h7F,8'h80), 8'hC5, 0, 0, 0); expect_done(1, 1'b1, "R3 msb set");
    issue(mk(1,1,0,0,0,8'h7F,8'h80), 8'h45, 0, 0, 0); expect_done(1, 1'b0, "R3 msb clear");
    issue(mk(1,1,0,0,0,8'h00,8'h3C), 8'h3C, 0, 0, 0); expect_done(1, 1'b1, "R3 exact match");
    issue(mk(1,1,0,0,0,8'h00,8'h3C), 8'h3D, 0, 0, 0); expect_done(1, 1'b0, "R3 lsb differs");
    issue(mk(1,1,0,0,0,8'hFF,8'h00), 8'hA7, 0, 0, 0); expect_done(1, 1'b1, "R3 all masked");
  endtask

  task automatic t_phase;
    issue(mk(1,0,1,0,3'b010,0,8'h11), 8'h99, 3'b010, 0, 0); expect_done(1, 1'b1, "R4 phase match");
    issue(mk(1,0,1,0,3'b010,0,0), 8'h00, 3'b011, 0, 0); expect_done(1, 1'b0, "R4 phase differs");
  endtask

  task automatic t_target;
    issue(mk(1,0,1,0,3'b101,0,0), 0, 3'b000, 1, 1); expect_done(1, 1'b1, "R5 atn high");
    issue(mk(1,0,1,0,3'b101,0,0), 0, 3'b101, 1, 0); expect_done(1, 1'b0, "R5 atn low phase match");
  endtask

  task automatic t_combine;
    issue(mk(1,1,1,0,3'b001,0,8'h55), 8'h54, 3'b001, 0, 0); expect_done(1, 1'b0, "R6 phase ok data bad");
    issue(mk(1,1,1,0,3'b001,0,8'h55), 8'h55, 3'b000, 0, 0); expect_done(1, 1'b0, "R6 data ok phase bad");
    issue(mk(1,1,1,0,3'b001,0,8'h55), 8'h55, 3'b001, 0, 0); expect_done(1, 1'b1, "R6 both ok");
    issue(mk(1,0,0,0,0,0,0), 8'hFF, 3'b111, 0, 0); expect_done(1, 1'b1, "R6 none enabled");
  endtask

  task automatic t_polarity;
    issue(mk(0,1,0,0,0,0,8'h10), 8'h11, 0, 0, 0); expect_done(1, 1'b1, "R7 jump on false");
    issue(mk(0,1,0,0,0,0,8'h10), 8'h10, 0, 0, 0); expect_done(1, 1'b0, "R7 no jump on true");
    issue(mk(0,0,0,0,0,0,0), 0, 0, 0, 0); expect_done(1, 1'b0, "R7 none enabled false pol");
  endtask

  task automatic t_wait;
    bit seen = 0;
    // first waiting instruction after reset: nothing pending (R1)
    issue(mk(1,0,1,1,3'b110,0,0), 0, 3'b000, 0, 0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i);
      if (done_o) seen = 1;
    end
    chk(seen, 1'b0, "R1 R8 stall without new phase");
    strobe_phase(3'b110);
    expect_done(2, 1'b1, "R8 decide after strobe");
    // consumed phase must not satisfy the next wait
    issue(mk(1,0,1,1,3'b110,0,0), 0, 3'b110, 0, 0);
    seen = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      if (done_o) seen = 1;
    end
    chk(seen, 1'b0, "R9 consumed phase not reused");
    strobe_phase(3'b011);
    expect_done(2, 1'b0, "R8 compare uses new phase");
    // strobe before start is retained
    strobe_phase(3'b100);
    issue(mk(1,0,1,1,3'b100,0,0), 0, 3'b100, 0, 0);
    expect_done(2, 1'b1, "R9 early strobe kept");
  endtask

  task automatic t_busy_start;
    int pulses = 0;
    issue(mk(1,0,1,1,3'b001,0,0), 0, 3'b000, 0, 0);
    @(negedge clk_i);
    ctrl_i = mk(0,0,0,0,0,0,0); start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    strobe_phase(3'b001);
    expect_done(2, 1'b1, "R10 original instruction kept");
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      if (done_o) pulses++;
    end
    chk_int(pulses, 0, "R10 no second decision");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired (all requirements)");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_data_mask();
    t_phase();
    t_target();
    t_combine();
    t_polarity();
    t_wait();
    t_busy_start();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule